// File: doc/BRIEF.md
# Transactional cache access tracker

This block holds the tag and state array of a small direct-mapped cache that runs hardware transactions. Every line keeps a tag and four flags: valid, modified, read-set and write-set. Processor loads and stores come in on one port. The block reports hit or miss, the coherence request that a miss needs, and whether a write-back must come first. A snoop port looks up incoming shared or exclusive coherence requests. It raises a conflict when such a request collides with the running transaction's read or write set.

Control strobes start, commit and abort a transaction. A commit takes the global commit lock first. It then walks the write-set lines in index order and obtains exclusive ownership of each one through a request/grant handshake. After that the transaction is validated: it can no longer be aborted, and snoops stop raising conflicts. The read and write sets are then cleared in one cycle and the lock is released. An abort drops every tracked line in one cycle. A transaction that reports itself as starving takes the commit lock when it starts.

Addresses on every port are line addresses, with the byte offset removed. The low `log2(NUM_LINES)` bits select the line and the remaining bits form the tag.

Top module: `txn_cache_tracker`

## Requirements
- R1: After reset no transaction is active, `lockReq`, `exclReq`, `conflict` and `rspValid` are 0, and every line is invalid, so the first access to any address misses.
- R2: An accepted access gives `rspValid` high for exactly the cycle after it is presented, with `rspHit`, `rspCoh` and `rspWriteBack`. `rspCoh` encodes 0 = none, 1 = shared request, 2 = exclusive request. A hit reports 0. Outside a transaction a load miss reports 1, a store miss reports 2 and leaves the line modified, and a store hit marks the line modified. A miss that replaces a valid modified line raises `rspWriteBack`.
- R3: Inside a transaction a load that misses reports code 1 and installs the line in the read set. A load that hits adds the line to the read set.
- R4: Inside a transaction a store that misses reports code 1 (shared, never exclusive) and installs the line in the write set.
- R5: Inside a transaction a store that hits a modified line raises `rspWriteBack` and puts the line in the write set.
- R6: `conflict` is high for the one cycle after a snoop that hits a line of an unvalidated transaction where either the snoop is exclusive (`snpExcl`=1) and the line is in the read set, or the line is in the write set. A shared snoop to a read-set-only line, a snoop to an untracked line, and any snoop while no transaction runs give no conflict.
- R7: `txnAbort` during an unvalidated transaction ends it in one cycle. Lines in the read or write set become invalid, other lines keep their contents, and the lock is dropped.
- R8: On `txnCommit` the block raises `lockReq` and waits for `lockGrant`. It then presents `exclReq` with `exclLine` for each write-set line in increasing index order and holds each request stable until `exclGrant`. It then sets `txnValidated`, clears the sets, and in the following cycle drops `lockReq` while `commitDone` pulses.
- R9: Once `txnValidated` is high, snoops raise no conflict. Write-set lines remain as modified committed data, and read-set membership is gone in the next transaction.
- R10: `txnBegin` with `txnStarving` set first raises `lockReq`. `txnActive` rises only after `lockGrant`, and the lock is kept through to the commit.
- R11: Processor accesses presented while a commit is in progress are ignored and produce no `rspValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Processor access valid |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuLine | input | LINE_AW (28) | Processor line address |
| rspValid | output | 1 | Access response valid |
| rspHit | output | 1 | Access hit |
| rspCoh | output | 2 | Coherence request needed (0 none, 1 shared, 2 exclusive) |
| rspWriteBack | output | 1 | Modified data must be written back |
| snpValid | input | 1 | Snooped request valid |
| snpExcl | input | 1 | Snooped request is exclusive |
| snpLine | input | LINE_AW (28) | Snooped line address |
| conflict | output | 1 | One-cycle transactional conflict pulse |
| txnBegin | input | 1 | Start a transaction |
| txnStarving | input | 1 | Starting transaction is starving |
| txnCommit | input | 1 | Commit the running transaction |
| txnAbort | input | 1 | Abort the running transaction |
| txnActive | output | 1 | A transaction is running or committing |
| txnValidated | output | 1 | The committing transaction is validated |
| commitDone | output | 1 | Commit finished, lock released |
| lockReq | output | 1 | Commit lock requested or held |
| lockGrant | input | 1 | Commit lock granted (level) |
| exclReq | output | 1 | Exclusive ownership request for a write-set line |
| exclLine | output | LINE_AW (28) | Line address of the exclusive request |
| exclGrant | input | 1 | Exclusive ownership granted |

## Verification
Accesses are exercised in four patterns: outside a transaction, as transactional loads, as transactional stores to absent lines, and as transactional stores to modified lines. Comparing the coherence code and the write-back flag across these patterns separates the non-transactional rules from the deferred-ownership rules. Snoops of both kinds are aimed at read-set, write-set and untracked lines, and also at lines while no transaction runs. Commits run with write-set lines out of index order and a delayed first grant, which exposes ordering and hold errors. A probe in the validated cycle, a transactional store after commit, and a starving start check the lock and post-commit rules.

// File: rtl/txn_trk_pkg.sv
package txn_trk_pkg;

  typedef enum logic [1:0] {
    COH_NONE   = 2'd0,
    COH_SHARED = 2'd1,
    COH_EXCL   = 2'd2
  } coh_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BEGIN_WAIT,
    ST_ACTIVE,
    ST_LOCK_WAIT,
    ST_ACQUIRE,
    ST_CLEAR,
    ST_RELEASE
  } ctl_state_e;

  // strobes from control to the line array
  typedef struct packed {
    logic cpuEn;
    logic txnMode;
    logic snpArm;
    logic clearSets;
    logic abortInv;
  } arr_strobe_t;

endpackage

// File: rtl/txn_trk_array.sv
module txn_trk_array
  import txn_trk_pkg::*;
#(
  parameter int LINE_AW   = 28,
  parameter int NUM_LINES = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  arr_strobe_t             strobe,
  input  logic                    cpuWrite,
  input  logic [LINE_AW-1:0]      cpuLine,
  input  logic                    snpValid,
  input  logic                    snpExcl,
  input  logic [LINE_AW-1:0]      snpLine,
  input  logic [$clog2(NUM_LINES)-1:0] scanIdx,
  output logic                    scanW,
  output logic [LINE_AW-1:0]      scanLine,
  output logic                    rspValid,
  output logic                    rspHit,
  output logic [1:0]              rspCoh,
  output logic                    rspWriteBack,
  output logic                    conflict
);

  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = LINE_AW - IDX_W;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             valid;
    logic             dirty;
    logic             rd;
    logic             wr;
  } line_t;

  line_t lineArr [NUM_LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  line_t            cpuEnt, snpEnt, scanEnt;
  logic             cpuHit, snpHit;

  assign cpuIdx  = cpuLine[IDX_W-1:0];
  assign cpuTag  = cpuLine[LINE_AW-1:IDX_W];
  assign snpIdx  = snpLine[IDX_W-1:0];
  assign snpTag  = snpLine[LINE_AW-1:IDX_W];
  assign cpuEnt  = lineArr[cpuIdx];
  assign snpEnt  = lineArr[snpIdx];
  assign scanEnt = lineArr[scanIdx];
  assign cpuHit  = cpuEnt.valid && (cpuEnt.tag == cpuTag);
  assign snpHit  = snpEnt.valid && (snpEnt.tag == snpTag);

  assign scanW    = scanEnt.valid && scanEnt.wr;
  assign scanLine = {scanEnt.tag, scanIdx};

  // one state register per line; bulk operations reach all lines at once
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic selThis;
    assign selThis = strobe.cpuEn && (cpuIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lineArr[i] <= '0;
      end else if (strobe.abortInv) begin
        if (lineArr[i].rd || lineArr[i].wr) lineArr[i].valid <= 1'b0;
        lineArr[i].rd <= 1'b0;
        lineArr[i].wr <= 1'b0;
      end else if (strobe.clearSets) begin
        if (lineArr[i].wr) lineArr[i].dirty <= 1'b1;
        lineArr[i].rd <= 1'b0;
        lineArr[i].wr <= 1'b0;
      end else if (selThis) begin
        if (cpuHit) begin
          if (strobe.txnMode) begin
            if (cpuWrite) begin
              lineArr[i].dirty <= 1'b0;
              lineArr[i].wr    <= 1'b1;
            end else if (!lineArr[i].wr) begin
              lineArr[i].rd <= 1'b1;
            end
          end else if (cpuWrite) begin
            lineArr[i].dirty <= 1'b1;
          end
        end else begin
          lineArr[i].tag   <= cpuTag;
          lineArr[i].valid <= 1'b1;
          lineArr[i].rd    <= strobe.txnMode && !cpuWrite;
          lineArr[i].wr    <= strobe.txnMode && cpuWrite;
          lineArr[i].dirty <= !strobe.txnMode && cpuWrite;
        end
      end
    end
  end

  coh_e missCoh;
  always_comb begin
    if (strobe.txnMode || !cpuWrite) missCoh = COH_SHARED;
    else                             missCoh = COH_EXCL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspHit       <= 1'b0;
      rspCoh       <= COH_NONE;
      rspWriteBack <= 1'b0;
    end else begin
      rspValid <= strobe.cpuEn;
      if (strobe.cpuEn) begin
        rspHit       <= cpuHit;
        rspCoh       <= cpuHit ? COH_NONE : missCoh;
        rspWriteBack <= cpuHit ? (strobe.txnMode && cpuWrite && cpuEnt.dirty)
                               : (cpuEnt.valid && cpuEnt.dirty);
      end else begin
        rspHit       <= 1'b0;
        rspCoh       <= COH_NONE;
        rspWriteBack <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) conflict <= 1'b0;
    else       conflict <= strobe.snpArm && snpValid && snpHit &&
                           ((snpExcl && snpEnt.rd) || snpEnt.wr);
  end

endmodule

// File: rtl/txn_trk_ctrl.sv
module txn_trk_ctrl
  import txn_trk_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuReq,
  input  logic                         txnBegin,
  input  logic                         txnStarving,
  input  logic                         txnCommit,
  input  logic                         txnAbort,
  input  logic                         lockGrant,
  input  logic                         exclGrant,
  input  logic                         scanW,
  output arr_strobe_t                  strobe,
  output logic [$clog2(NUM_LINES)-1:0] scanIdx,
  output logic                         lockReq,
  output logic                         exclReq,
  output logic                         txnActive,
  output logic                         txnValidated,
  output logic                         commitDone
);

  localparam int               IDX_W    = $clog2(NUM_LINES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  ctl_state_e       stateQ;
  logic             lockHeld;
  logic [IDX_W-1:0] ptrQ;
  logic             abortOk, armed, stepOk;

  assign armed   = (stateQ == ST_ACTIVE) || (stateQ == ST_LOCK_WAIT) ||
                   (stateQ == ST_ACQUIRE);
  assign abortOk = txnAbort && armed;
  assign stepOk  = !scanW || exclGrant;

  always_comb begin
    strobe.cpuEn     = cpuReq && ((stateQ == ST_IDLE) ||
                       ((stateQ == ST_ACTIVE) && !txnAbort && !txnCommit));
    strobe.txnMode   = (stateQ == ST_ACTIVE);
    strobe.snpArm    = armed;
    strobe.clearSets = (stateQ == ST_CLEAR);
    strobe.abortInv  = abortOk;
  end

  assign scanIdx      = ptrQ;
  assign exclReq      = (stateQ == ST_ACQUIRE) && scanW;
  assign lockReq      = lockHeld || (stateQ == ST_BEGIN_WAIT) || (stateQ == ST_LOCK_WAIT);
  assign txnActive    = (stateQ != ST_IDLE) && (stateQ != ST_BEGIN_WAIT);
  assign txnValidated = (stateQ == ST_CLEAR) || (stateQ == ST_RELEASE);
  assign commitDone   = (stateQ == ST_RELEASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      lockHeld <= 1'b0;
      ptrQ     <= '0;
    end else if (abortOk) begin
      stateQ   <= ST_IDLE;
      lockHeld <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (txnBegin) stateQ <= txnStarving ? ST_BEGIN_WAIT : ST_ACTIVE;
        end
        ST_BEGIN_WAIT: begin
          if (lockGrant) begin
            lockHeld <= 1'b1;
            stateQ   <= ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          if (txnCommit) begin
            ptrQ   <= '0;
            stateQ <= lockHeld ? ST_ACQUIRE : ST_LOCK_WAIT;
          end
        end
        ST_LOCK_WAIT: begin
          if (lockGrant) begin
            lockHeld <= 1'b1;
            ptrQ     <= '0;
            stateQ   <= ST_ACQUIRE;
          end
        end
        ST_ACQUIRE: begin
          if (stepOk) begin
            if (ptrQ == LAST_IDX) stateQ <= ST_CLEAR;
            else                  ptrQ   <= ptrQ + 1'b1;
          end
        end
        ST_CLEAR: begin
          lockHeld <= 1'b0;
          stateQ   <= ST_RELEASE;
        end
        ST_RELEASE: stateQ <= ST_IDLE;
        default:    stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txn_cache_tracker.sv
module txn_cache_tracker
  import txn_trk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_AW   = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuReq,
  input  logic               cpuWrite,
  input  logic [LINE_AW-1:0] cpuLine,
  output logic               rspValid,
  output logic               rspHit,
  output logic [1:0]         rspCoh,
  output logic               rspWriteBack,
  input  logic               snpValid,
  input  logic               snpExcl,
  input  logic [LINE_AW-1:0] snpLine,
  output logic               conflict,
  input  logic               txnBegin,
  input  logic               txnStarving,
  input  logic               txnCommit,
  input  logic               txnAbort,
  output logic               txnActive,
  output logic               txnValidated,
  output logic               commitDone,
  output logic               lockReq,
  input  logic               lockGrant,
  output logic               exclReq,
  output logic [LINE_AW-1:0] exclLine,
  input  logic               exclGrant
);

  localparam int IDX_W = $clog2(NUM_LINES);

  arr_strobe_t      strobe;
  logic [IDX_W-1:0] scanIdx;
  logic             scanW;

  txn_trk_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReq       (cpuReq),
    .txnBegin     (txnBegin),
    .txnStarving  (txnStarving),
    .txnCommit    (txnCommit),
    .txnAbort     (txnAbort),
    .lockGrant    (lockGrant),
    .exclGrant    (exclGrant),
    .scanW        (scanW),
    .strobe       (strobe),
    .scanIdx      (scanIdx),
    .lockReq      (lockReq),
    .exclReq      (exclReq),
    .txnActive    (txnActive),
    .txnValidated (txnValidated),
    .commitDone   (commitDone)
  );

  txn_trk_array #(.LINE_AW(LINE_AW), .NUM_LINES(NUM_LINES)) u_array (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cpuWrite     (cpuWrite),
    .cpuLine      (cpuLine),
    .snpValid     (snpValid),
    .snpExcl      (snpExcl),
    .snpLine      (snpLine),
    .scanIdx      (scanIdx),
    .scanW        (scanW),
    .scanLine     (exclLine),
    .rspValid     (rspValid),
    .rspHit       (rspHit),
    .rspCoh       (rspCoh),
    .rspWriteBack (rspWriteBack),
    .conflict     (conflict)
  );

endmodule

// File: rtl/txn_trk_checker.sv
module txn_trk_checker #(
  parameter int LINE_AW = 28
) (
  input logic               clk,
  input logic               rstN,
  input logic               rspValid,
  input logic               rspHit,
  input logic [1:0]         rspCoh,
  input logic               conflict,
  input logic               txnAbort,
  input logic               txnActive,
  input logic               txnValidated,
  input logic               commitDone,
  input logic               lockReq,
  input logic               exclReq,
  input logic [LINE_AW-1:0] exclLine,
  input logic               exclGrant
);

  AST_HIT_NO_COH: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspHit |-> rspCoh == 2'd0); // R2

  AST_TXN_MISS_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspHit && $past(txnActive) |-> rspCoh == 2'd1); // R4

  AST_EXCL_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    exclReq |-> lockReq && txnActive && !txnValidated); // R8

  AST_EXCL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    exclReq && !exclGrant && !txnAbort |=> exclReq && $stable(exclLine)); // R8

  AST_DONE_LOCK_FREE: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |-> !lockReq && txnValidated); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |=> !commitDone && !txnActive); // R8

  AST_NO_CONFLICT_VALIDATED: assert property (@(posedge clk) disable iff (!rstN)
    conflict |-> $past(txnActive && !txnValidated)); // R9

  AST_NO_CONFLICT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !txnActive |=> !conflict); // R6

endmodule

bind txn_cache_tracker txn_trk_checker #(.LINE_AW(LINE_AW)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rspValid     (rspValid),
  .rspHit       (rspHit),
  .rspCoh       (rspCoh),
  .conflict     (conflict),
  .txnAbort     (txnAbort),
  .txnActive    (txnActive),
  .txnValidated (txnValidated),
  .commitDone   (commitDone),
  .lockReq      (lockReq),
  .exclReq      (exclReq),
  .exclLine     (exclLine),
  .exclGrant    (exclGrant)
);

// File: tb/test_txn_cache_tracker.sv
`timescale 1ns/1ps
module test_txn_cache_tracker;

  localparam int LAW = 28;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 0, cpuWrite = 0;
  logic [LAW-1:0] cpuLine = '0;
  logic rspValid, rspHit, rspWriteBack;
  logic [1:0] rspCoh;
  logic snpValid = 0, snpExcl = 0;
  logic [LAW-1:0] snpLine = '0;
  logic conflict;
  logic txnBegin = 0, txnStarving = 0, txnCommit = 0, txnAbort = 0;
  logic txnActive, txnValidated, commitDone, lockReq, exclReq;
  logic lockGrant = 0, exclGrant = 0;
  logic [LAW-1:0] exclLine;

  int nChecks = 0;
  int nErr = 0;

  // line addresses: low 4 bits select the line
  localparam logic [LAW-1:0] LA = 28'h0000013, LB = 28'h0000023, LC = 28'h0000034,
    LD = 28'h0000046, LE = 28'h0000057, LF = 28'h0000068, LP = 28'h0000075,
    LQ = 28'h0000082, LS = 28'h0000099, LT = 28'h00000AB;

  always #2.5 clk = ~clk;

  txn_cache_tracker i_txn_cache_tracker (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuLine(cpuLine),
    .rspValid(rspValid), .rspHit(rspHit), .rspCoh(rspCoh), .rspWriteBack(rspWriteBack),
    .snpValid(snpValid), .snpExcl(snpExcl), .snpLine(snpLine), .conflict(conflict),
    .txnBegin(txnBegin), .txnStarving(txnStarving), .txnCommit(txnCommit),
    .txnAbort(txnAbort), .txnActive(txnActive), .txnValidated(txnValidated),
    .commitDone(commitDone), .lockReq(lockReq), .lockGrant(lockGrant),
    .exclReq(exclReq), .exclLine(exclLine), .exclGrant(exclGrant)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input string req, input logic [LAW-1:0] line, input logic wr,
                        input logic expHit, input logic [1:0] expCoh, input logic expWb);
    @(negedge clk);
    cpuReq = 1; cpuWrite = wr; cpuLine = line;
    @(negedge clk);
    cpuReq = 0; cpuWrite = 0;
    chk(req, "rspValid", rspValid, 1);
    chk(req, "rspHit", rspHit, expHit);
    chk(req, "rspCoh", rspCoh, expCoh);
    chk(req, "rspWriteBack", rspWriteBack, expWb);
  endtask

  task automatic snoop(input string req, input logic [LAW-1:0] line, input logic excl,
                       input logic expConf);
    @(negedge clk);
    snpValid = 1; snpExcl = excl; snpLine = line;
    @(negedge clk);
    snpValid = 0; snpExcl = 0;
    chk(req, "conflict", conflict, expConf);
  endtask

  task automatic beginTxn();
    @(negedge clk); txnBegin = 1;
    @(negedge clk); txnBegin = 0;
    chk("R3", "txnActive after begin", txnActive, 1);
  endtask

  task automatic abortTxn();
    @(negedge clk); txnAbort = 1;
    @(negedge clk); txnAbort = 0;
    chk("R7", "txnActive after abort", txnActive, 0);
    chk("R7", "lockReq after abort", lockReq, 0);
  endtask

  task automatic commitRun(input logic [LAW-1:0] exp0, input logic [LAW-1:0] exp1,
                           input int expN, input logic holdFirst);
    int nReq = 0;
    int waitCnt = 0;
    bit sawVal = 0, fin = 0, snpPend = 0;
    logic [LAW-1:0] heldLine = '0;
    logic [LAW-1:0] got [2];
    got[0] = '0; got[1] = '0;
    @(negedge clk); txnCommit = 1;
    @(negedge clk); txnCommit = 0;
    cpuReq = 1; cpuWrite = 0; cpuLine = LA;
    @(negedge clk);
    cpuReq = 0;
    chk("R11", "rspValid during commit", rspValid, 0);
    for (int cyc = 0; cyc < 300 && !fin; cyc++) begin
      exclGrant = 0;
      if (snpPend) begin
        chk("R9", "conflict after validation", conflict, 0);
        snpValid = 0; snpExcl = 0; snpPend = 0;
      end
      if (lockReq) lockGrant = 1;
      if (exclReq) begin
        if (holdFirst && nReq == 0 && waitCnt < 2) begin
          if (waitCnt == 0) heldLine = exclLine;
          else chk("R8", "exclLine held", exclLine, heldLine);
          waitCnt++;
        end else begin
          if (nReq < 2) got[nReq] = exclLine;
          nReq++;
          exclGrant = 1;
        end
      end
      if (txnValidated && !sawVal) begin
        sawVal = 1;
        chk("R8", "requests before validation", nReq, expN);
        snpValid = 1; snpExcl = 1; snpLine = exp0;
        snpPend = 1;
      end
      if (commitDone) begin
        chk("R8", "lockReq at done", lockReq, 0);
        chk("R8", "validated before done", sawVal, 1);
        fin = 1;
        lockGrant = 0;
      end
      @(negedge clk);
    end
    chk("R8", "commit finished", fin, 1);
    chk("R8", "first exclusive line", got[0], exp0);
    if (expN > 1) chk("R8", "second exclusive line", got[1], exp1);
    chk("R8", "txnActive after commit", txnActive, 0);
  endtask

  task automatic t_reset();
    chk("R1", "txnActive", txnActive, 0);
    chk("R1", "lockReq", lockReq, 0);
    chk("R1", "exclReq", exclReq, 0);
    chk("R1", "conflict", conflict, 0);
    chk("R1", "rspValid", rspValid, 0);
  endtask

  task automatic t_plain();
    access("R1", LA, 1, 0, 2, 0);   // store miss: exclusive request
    access("R2", LA, 1, 1, 0, 0);   // store hit
    access("R2", LB, 0, 0, 1, 1);   // evicts modified A
    @(negedge clk);
    chk("R2", "rspValid one cycle only", rspValid, 0);
  endtask

  task automatic t_txn_load();
    beginTxn();
    access("R3", LC, 0, 0, 1, 0);
    snoop("R6", LC, 0, 0);          // shared on read set
    snoop("R3", LC, 1, 1);          // exclusive on read set
    @(negedge clk);
    chk("R6", "conflict single pulse", conflict, 0);
    snoop("R6", LS, 1, 0);          // absent line
    abortTxn();
    access("R7", LC, 0, 0, 1, 0);   // read-set line dropped
    snoop("R6", LC, 1, 0);          // no transaction
  endtask

  task automatic t_txn_store();
    access("R2", LD, 1, 0, 2, 0);
    access("R2", LF, 0, 0, 1, 0);
    beginTxn();
    access("R5", LD, 1, 1, 0, 1);
    snoop("R6", LD, 0, 1);          // shared on write set
    access("R4", LE, 1, 0, 1, 0);
    snoop("R4", LE, 0, 1);
    snoop("R6", LF, 1, 0);          // untracked line
    abortTxn();
    access("R7", LD, 0, 0, 1, 0);
    access("R7", LF, 0, 1, 0, 0);   // untracked line kept
  endtask

  task automatic t_commit();
    beginTxn();
    access("R4", LP, 1, 0, 1, 0);
    access("R4", LQ, 1, 0, 1, 0);
    access("R3", LS, 0, 0, 1, 0);
    commitRun(LQ, LP, 2, 1);
    beginTxn();
    snoop("R9", LS, 1, 0);          // read set cleared by commit
    access("R9", LQ, 1, 1, 0, 1);   // committed data is modified
    abortTxn();
  endtask

  task automatic t_starving();
    @(negedge clk); txnBegin = 1; txnStarving = 1;
    @(negedge clk); txnBegin = 0; txnStarving = 0;
    chk("R10", "lockReq at start", lockReq, 1);
    chk("R10", "txnActive before grant", txnActive, 0);
    @(negedge clk);
    chk("R10", "still waiting", txnActive, 0);
    lockGrant = 1;
    @(negedge clk);
    chk("R10", "txnActive after grant", txnActive, 1);
    chk("R10", "lock kept", lockReq, 1);
    access("R10", LT, 1, 0, 1, 0);
    chk("R10", "lock kept through body", lockReq, 1);
    commitRun(LT, LT, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_txn_load();
    t_txn_store();
    t_commit();
    t_starving();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule